// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept. The six destination address bytes arrive one per clock, in the order they appear on the wire. While they arrive, the block does three things. It compares them with a programmed 48-bit station address. It checks whether all of them are ones, which marks a broadcast. It runs a bit-serial CRC over them, and the CRC yields a six-bit index into a 64-bit multicast hash table.

One cycle after the sixth byte, a one-cycle done strobe marks a valid accept decision. A promiscuous enable overrides every class test. The broadcast and multicast classes each have their own enable. A start pulse readies the block for the next frame.

Top module: `rx_addr_screen`

## Requirements
- R1: After reset, done and accept are 0 and hash_idx is 6'h3F (the CRC starts at all ones).
- R2: The CRC starts at 32'hFFFFFFFF and takes each byte least significant bit first, 48 bits in all. For each bit, feedback is CRC bit 31 XOR the data bit. The register then shifts left by one place. When feedback is 1, the register is XORed with 32'h04C11DB6 and bit 0 is set to 1. After the sixth byte, hash_idx shows CRC bits 31..26.
- R3: When promisc_en is 1, every frame is accepted.
- R4: A destination of six 8'hFF bytes is accepted only when bcast_en is 1 (or promisc_en is 1). It is never treated as multicast or as a station match.
- R5: Any other destination whose first byte has bit 0 set is multicast. It is accepted only when mcast_en is 1 and hash_table[hash_idx] is 1. That flat bit is bit hash_idx[2:0] of table byte hash_idx[5:3], with byte k at hash_table[8k+7:8k].
- R6: Every remaining destination is accepted only when all six bytes equal station_addr. The byte that arrives k-th (k = 0..5) is compared with station_addr[8k+7:8k]. The mode enables have no effect on this comparison.
- R7: done is high for exactly one cycle, the cycle after the sixth byte is taken. accept is valid in that cycle and holds until the next start.
- R8: start clears the CRC, the byte count, the comparison state and accept. A byte offered in the same cycle as start is ignored. Bytes after the sixth are ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new frame; clears all per-frame state |
| byte_valid | input | 1 | byte_in carries an address byte this cycle |
| byte_in | input | 8 | Destination address byte |
| station_addr | input | 48 | Station address; wire byte k at [8k+7:8k] |
| hash_table | input | 64 | Multicast hash table, indexed by hash_idx |
| promisc_en | input | 1 | Accept every frame |
| bcast_en | input | 1 | Accept broadcast frames |
| mcast_en | input | 1 | Accept multicast frames whose hash bit is set |
| done | output | 1 | One-cycle strobe: the decision is valid |
| accept | output | 1 | Decision: 1 keeps the frame |
| hash_idx | output | 6 | Top six CRC bits (the hash index) |

## Verification
The filter is driven with several kinds of address:
- Unicast addresses that match the station, and ones that differ only in the last byte, to show the comparison covers all six bytes.
- The broadcast address with its enable on and off, and with the station address also set to all ones, to show that class order decides the result.
- Multicast addresses checked against a reference CRC, using four tables: all ones, all zeros, only the expected bit set, and every bit except the expected one. This exposes any error in the index or the bit order.
- Random multicast addresses with random tables, promiscuous frames, a seventh byte, and a byte offered together with start, to check the framing rules.

// File: rtl/rx_addr_screen.sv
module rx_addr_screen #(
  parameter int NBYTES = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        byte_valid,
  input  logic [7:0]  byte_in,
  input  logic [47:0] station_addr,
  input  logic [63:0] hash_table,
  input  logic        promisc_en,
  input  logic        bcast_en,
  input  logic        mcast_en,
  output logic        done,
  output logic        accept,
  output logic [5:0]  hash_idx
);
  localparam int CW = $clog2(NBYTES + 1);
  localparam logic [31:0] POLY = 32'h04C11DB6;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int j = 0; j < 8; j++) begin
      fb = r[31] ^ b[j];
      r = {r[30:0], 1'b0};
      if (fb) r = (r ^ POLY) | 32'd1;
    end
    return r;
  endfunction

  logic [31:0]   crc_q;
  logic [CW-1:0] cnt_q;
  logic          bc_q, stn_q, grp_q;

  wire take = byte_valid && !start && (cnt_q < CW'(NBYTES));
  wire last = take && (cnt_q == CW'(NBYTES - 1));

  logic [31:0] crc_n;
  logic        bc_n, stn_n, grp_n, verdict;
  logic [5:0]  idx_n;

  always_comb begin
    crc_n   = crc_step(crc_q, byte_in);
    idx_n   = crc_n[31:26];
    bc_n    = bc_q && (byte_in == 8'hFF);
    stn_n   = stn_q && (byte_in == station_addr[{cnt_q, 3'b000} +: 8]);
    grp_n   = (cnt_q == '0) ? byte_in[0] : grp_q;
    verdict = promisc_en | (bc_n  ? bcast_en :
                            grp_n ? (mcast_en & hash_table[idx_n]) : stn_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      crc_q  <= '1;
      cnt_q  <= '0;
      bc_q   <= 1'b1;
      stn_q  <= 1'b1;
      grp_q  <= 1'b0;
      done   <= 1'b0;
      accept <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        crc_q <= crc_n;
        cnt_q <= cnt_q + 1'b1;
        bc_q  <= bc_n;
        stn_q <= stn_n;
        grp_q <= grp_n;
      end
      if (last) begin
        done   <= 1'b1;
        accept <= verdict;
      end
    end
  end

  assign hash_idx = crc_q[31:26];

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(byte_valid) && !$past(start));
  a_r3_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(promisc_en)) |-> accept);
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (!done && !accept && hash_idx == 6'h3F));
  a_r7_accept_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(start)) |-> $stable(accept));
endmodule

// File: tb/rx_addr_screen_test.sv
module rx_addr_screen_test;
  logic clk = 0, rst_n = 0, start = 0, byte_valid = 0;
  logic [7:0]  byte_in = 0;
  logic [47:0] station_addr = 48'h0;
  logic [63:0] hash_table = 64'h0;
  logic promisc_en = 0, bcast_en = 0, mcast_en = 0;
  logic done, accept;
  logic [5:0] hash_idx;

  int tests = 0, fails = 0, cycles = 0;
  bit exp_acc_q[$];
  logic [5:0] exp_idx_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  rx_addr_screen uut (.*);

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[31] ^ a[i];
      c = c << 1;
      if (fb) c = (c ^ 32'h04C11DB6) | 32'd1;
    end
    return c;
  endfunction

  function automatic bit ref_accept(input logic [47:0] a);
    logic [5:0] ix = ref_crc(a)[31:26];
    if (promisc_en) return 1;
    if (a == {48{1'b1}}) return bcast_en;
    if (a[0]) return mcast_en && hash_table[ix];
    return a == station_addr;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic send(input logic [47:0] a, input string req, input int nbytes = 6,
                      input bit junk_with_start = 0);
    exp_acc_q.push_back(ref_accept(a));
    exp_idx_q.push_back(ref_crc(a)[31:26]);
    tag_q.push_back(req);
    @(negedge clk);
    start = 1;
    if (junk_with_start) begin byte_valid = 1; byte_in = 8'h5A; end
    @(negedge clk);
    start = 0;
    for (int k = 0; k < nbytes; k++) begin
      byte_valid = 1;
      byte_in = (k < 6) ? a[8*k +: 8] : 8'hC3;
      @(negedge clk);
    end
    byte_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_acc_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R7/R8 unexpected done actual=1 expected=0");
      end else begin
        string t = tag_q.pop_front();
        check({t, " accept"}, accept, exp_acc_q.pop_front());
        check("R2 hash_idx", hash_idx, exp_idx_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [47:0] mc;
    logic [5:0] ix;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 done", done, 0);
    check("R1 accept", accept, 0);
    check("R1 hash_idx", hash_idx, 6'h3F);

    station_addr = 48'h665544332210;
    send(48'h665544332210, "R6 match");
    send(48'h775544332210, "R6 last byte differs");
    bcast_en = 1; mcast_en = 1; hash_table = '1;
    send(48'h665544332210, "R6 modes ignored");

    // start clears accept and hash
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    check("R8 accept cleared", accept, 0);
    check("R8 hash cleared", hash_idx, 6'h3F);

    bcast_en = 0;
    send({48{1'b1}}, "R4 bcast disabled");
    bcast_en = 1;
    send({48{1'b1}}, "R4 bcast enabled");
    station_addr = {48{1'b1}}; bcast_en = 0; hash_table = '1;
    send({48{1'b1}}, "R4 precedence over station");
    station_addr = 48'h665544332210;

    mc = 48'h0100005E0001;
    mc = {mc[7:0], mc[15:8], mc[23:16], mc[31:24], mc[39:32], mc[47:40]};
    ix = ref_crc(mc)[31:26];
    mcast_en = 1; hash_table = '1;  send(mc, "R5 table ones");
    hash_table = '0;                send(mc, "R5 table zeros");
    hash_table = 64'd1 << ix;       send(mc, "R5 only own bit");
    hash_table = ~(64'd1 << ix);    send(mc, "R5 all but own bit");
    mcast_en = 0; hash_table = '1;  send(mc, "R5 mcast disabled");

    promisc_en = 1;
    send(48'h123456789ABC, "R3 promisc unicast");
    send(mc, "R3 promisc multicast");
    promisc_en = 0;

    mcast_en = 1;
    for (int n = 0; n < 20; n++) begin
      logic [47:0] r = {$urandom, $urandom};
      r[0] = 1'b1;
      hash_table = {$urandom, $urandom};
      send(r, "R2/R5 random multicast");
    end

    send(48'h665544332210, "R8 seventh byte ignored", 7);
    send(48'h665544332210, "R8 byte with start ignored", 6, 1);
    bcast_en = 1;
    send(48'h665544332210, "R7 back to back");

    repeat (5) @(negedge clk);
    check("R7 all decisions seen", exp_acc_q.size(), 0);
    finish_run();
  end
endmodule